// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block selects which of five interrupt sources an 8-bit microcontroller core should service next. It then hands the core a request together with a 16-bit vector. The five sources are two external pins (active low), two timer overflow events and one serial source. The serial source is asserted while either its receive flag or its transmit flag is set. Every source has its own enable bit, and a global enable bit gates all of them. Every source also has a priority bit that places it at the high or the low level.

Each external pin passes through a synchronizer. It can then be read in one of two ways. In level mode a low pin requests for as long as it stays low. In edge mode a falling edge sets a latched flag. The core answers a request with a one-cycle acknowledge pulse, which marks that level as in service. A one-cycle return pulse ends the handler. A new request is offered only if it outranks every handler already in service, so a high-level handler can nest inside a low-level one. Two requests at the same level are resolved by a fixed polling order.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, the enable, priority and trigger-mode registers are all zero, nothing is in service, and `irq_req` is 0.
- R2: While the global enable (bit 5 of the enable word) is 0, `irq_req` stays 0 whatever sources are pending or individually enabled.
- R3: A pending source whose own enable bit is 0 never causes a request. The enable bits 0..4 map to external 0, timer 0, external 1, timer 1 and serial, in that order.
- R4: Among eligible sources at the same level, the winner is the first one in this polling order: external 0, timer 0, external 1, timer 1, serial.
- R5: A priority bit of 1 places its source at the high level. Any eligible high-level source beats every low-level source, whatever its place in the polling order. Priority bits use the same bit mapping as the enable bits.
- R6: `irq_vector` equals 0x0003 + 8 × source index. This gives 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial.
- R7: An acknowledge marks the winner's level as in service. A request is offered only when no handler of equal or higher level is in service. A high-level request therefore nests inside a low-level handler, but no request nests inside a high-level handler.
- R8: In level mode (mode bit 0, with bit 0 for external 0 and bit 1 for external 1), a low pin requests, and releasing the pin withdraws the request.
- R9: In edge mode (mode bit 1), a high-to-low transition sets a latched flag on the third rising clock edge after the pin falls. Acknowledging that source clears the flag.
- R10: A one-cycle timer overflow pulse sets a latched timer flag. Acknowledging that timer clears the flag.
- R11: The serial source requests while either its receive or transmit input is 1. An acknowledge does not clear it.
- R12: A return pulse clears the high in-service bit if it is set, and otherwise clears the low in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_we | input | 1 | Write strobe for the enable word |
| en_wdata | input | 6 | Enable word: bits 0..4 per source, bit 5 global |
| pri_we | input | 1 | Write strobe for the priority word |
| pri_wdata | input | 5 | Priority bits, 1 = high level |
| mode_we | input | 1 | Write strobe for the trigger-mode word |
| mode_wdata | input | 2 | Per external pin: 0 = level, 1 = falling edge |
| ext_n | input | 2 | External interrupt pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| irq_ack | input | 1 | Core acknowledges the offered request |
| irq_reti | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | 16 | Vector of the winning source |

## Verification
A vector table applies combinations of enable words, priority words and active pins, with both external pins and the serial source held at level. The rows tell the global gate apart from the per-source gates, and polling order apart from priority level. Some rows put two high-level sources against each other, so a correct priority override is distinguished from a plain "highest index wins" rule. Directed sequences then cover the latched sources:
- the edge flag is timed cycle by cycle through the synchronizer and shown to be cleared by acknowledge;
- a timer pulse is shown to be cleared by acknowledge;
- the serial source is shown to survive acknowledge.

A final nesting sequence acknowledges a low handler and a high handler in turn. It shows that equal-level requests are blocked, that a higher level preempts, and that each return pulse clears the proper in-service bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 5;
  localparam int NEXT    = 2;
  localparam int NTMR    = 2;
  localparam int SER_IDX = NSRC - 1;
  localparam int IDX_W   = $clog2(NSRC);

  typedef logic [NSRC-1:0]  src_vec_t;
  typedef logic [IDX_W-1:0] src_idx_t;

  // Lowest set index wins (polling order).
  function automatic src_idx_t first_idx(input src_vec_t v);
    src_idx_t r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = src_idx_t'(i);
    end
    return r;
  endfunction

  function automatic logic [15:0] vec_of(input src_idx_t idx,
                                         input logic [15:0] base,
                                         input int step_lg);
    return base + (16'(idx) << step_lg);
  endfunction
endpackage

// File: rtl/irq_ext_in.sv
module irq_ext_in #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic pend,
  output logic fall_seen
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   smp;

  assign smp = sh_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= smp;
    end
  end

  assign fall_seen = prev_q & ~smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (!edge_mode) flag_q <= 1'b0;
    else if (fall_seen)  flag_q <= 1'b1;
    else if (clr)        flag_q <= 1'b0;
  end

  assign pend = edge_mode ? flag_q : ~smp;
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
(
  input  src_vec_t pend_v,
  input  src_vec_t en_v,
  input  logic     glb_en,
  input  src_vec_t pri_v,
  input  logic     svc_hi,
  input  logic     svc_lo,
  output logic     req,
  output src_idx_t win_idx,
  output logic     win_hi
);
  src_vec_t elig, hi_set, lo_set;
  logic     blocked;

  assign elig    = pend_v & en_v & {NSRC{glb_en}};
  assign hi_set  = elig & pri_v;
  assign lo_set  = elig & ~pri_v;
  assign win_hi  = |hi_set;
  assign win_idx = win_hi ? first_idx(hi_set) : first_idx(lo_set);
  assign blocked = svc_hi | (~win_hi & svc_lo);
  assign req     = (|elig) & ~blocked;
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic svc_hi,
  output logic svc_lo
);
  logic hi_d, lo_d;

  always_comb begin
    hi_d = svc_hi;
    lo_d = svc_lo;
    if (reti) begin
      if (svc_hi) hi_d = 1'b0;
      else        lo_d = 1'b0;
    end
    if (take) begin
      if (take_hi) hi_d = 1'b1;
      else         lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else begin
      svc_hi <= hi_d;
      svc_lo <= lo_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter int          VEC_STEP_LG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic [NSRC:0]   en_wdata,
  input  logic            pri_we,
  input  logic [NSRC-1:0] pri_wdata,
  input  logic            mode_we,
  input  logic [NEXT-1:0] mode_wdata,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NTMR-1:0] tmr_ovf,
  input  logic            ser_rx,
  input  logic            ser_tx,
  input  logic            irq_ack,
  input  logic            irq_reti,
  output logic            irq_req,
  output logic [15:0]     irq_vector
);
  logic [NSRC:0]   en_q;
  src_vec_t        pri_q;
  logic [NEXT-1:0] mode_q;
  logic [NEXT-1:0] ext_fall;
  src_vec_t        pend, take_oh;
  src_idx_t        win_idx;
  logic            win_hi, take, svc_hi, svc_lo, glb_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pri_q  <= '0;
      mode_q <= '0;
    end else begin
      if (en_we)   en_q   <= en_wdata;
      if (pri_we)  pri_q  <= pri_wdata;
      if (mode_we) mode_q <= mode_wdata;
    end
  end

  assign glb_en = en_q[NSRC];
  assign take   = irq_ack & irq_req;

  always_comb begin
    take_oh = '0;
    if (take) take_oh[win_idx] = 1'b1;
  end

  for (genvar e = 0; e < NEXT; e++) begin : g_ext
    irq_ext_in #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_n[e]),
      .edge_mode (mode_q[e]),
      .clr       (take_oh[2*e]),
      .pend      (pend[2*e]),
      .fall_seen (ext_fall[e])
    );
  end

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (tmr_ovf[t])       flag_q <= 1'b1;
      else if (take_oh[2*t + 1]) flag_q <= 1'b0;
    end
    assign pend[2*t + 1] = flag_q;
  end

  assign pend[SER_IDX] = ser_rx | ser_tx;

  irq_select u_sel (
    .pend_v  (pend),
    .en_v    (en_q[NSRC-1:0]),
    .glb_en  (glb_en),
    .pri_v   (pri_q),
    .svc_hi  (svc_hi),
    .svc_lo  (svc_lo),
    .req     (irq_req),
    .win_idx (win_idx),
    .win_hi  (win_hi)
  );

  irq_svc_track u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .take_hi (win_hi),
    .reti    (irq_reti),
    .svc_hi  (svc_hi),
    .svc_lo  (svc_lo)
  );

  assign irq_vector = vec_of(win_idx, VEC_BASE, VEC_STEP_LG);
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic [15:0] irq_vector,
  input logic        irq_ack,
  input logic        irq_reti,
  input logic        glb_en,
  input logic        svc_hi,
  input logic        svc_lo
);
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req); // R2

  AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'b011 && irq_vector <= 16'h0023)); // R6

  AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi |-> !irq_req); // R7

  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !irq_reti) |=> (svc_hi || svc_lo)); // R7

  AST_RETI_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && svc_hi && !irq_ack) |=> !svc_hi); // R12

  AST_RETI_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && !svc_hi && svc_lo && !irq_ack) |=> !svc_lo); // R12
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .irq_vector (irq_vector),
  .irq_ack    (irq_ack),
  .irq_reti   (irq_reti),
  .glb_en     (glb_en),
  .svc_hi     (svc_hi),
  .svc_lo     (svc_lo)
);

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
module irq_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_we = 1'b0, pri_we = 1'b0, mode_we = 1'b0;
  logic [5:0]  en_wdata = '0;
  logic [4:0]  pri_wdata = '0;
  logic [1:0]  mode_wdata = '0;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tmr_ovf = '0;
  logic        ser_rx = 1'b0, ser_tx = 1'b0;
  logic        irq_ack = 1'b0, irq_reti = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vector;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .en_we(en_we), .en_wdata(en_wdata),
    .pri_we(pri_we), .pri_wdata(pri_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .irq_ack(irq_ack), .irq_reti(irq_reti),
    .irq_req(irq_req), .irq_vector(irq_vector)
  );

  // row: en[30:25] pri[24:20] ext_n[19:18] ser[17] req[16] vec[15:0]
  localparam int NROW = 11;
  localparam logic [30:0] TBL [NROW] = '{
    {6'b000000, 5'b00000, 2'b00, 1'b1, 1'b0, 16'h0000},
    {6'b011111, 5'b00000, 2'b00, 1'b1, 1'b0, 16'h0000},
    {6'b111111, 5'b00000, 2'b00, 1'b1, 1'b1, 16'h0003},
    {6'b111111, 5'b00000, 2'b01, 1'b1, 1'b1, 16'h0013},
    {6'b111111, 5'b10000, 2'b00, 1'b1, 1'b1, 16'h0023},
    {6'b111111, 5'b00100, 2'b00, 1'b1, 1'b1, 16'h0013},
    {6'b110000, 5'b00000, 2'b00, 1'b1, 1'b1, 16'h0023},
    {6'b100100, 5'b00000, 2'b00, 1'b1, 1'b1, 16'h0013},
    {6'b111111, 5'b10100, 2'b00, 1'b1, 1'b1, 16'h0013},
    {6'b111111, 5'b00000, 2'b11, 1'b0, 1'b0, 16'h0000},
    {6'b100001, 5'b00000, 2'b01, 1'b1, 1'b0, 16'h0000}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_en(input logic [5:0] v);
    en_wdata = v; en_we = 1'b1; cyc(1); en_we = 1'b0;
  endtask

  task automatic wr_pri(input logic [4:0] v);
    pri_wdata = v; pri_we = 1'b1; cyc(1); pri_we = 1'b0;
  endtask

  task automatic wr_mode(input logic [1:0] v);
    mode_wdata = v; mode_we = 1'b1; cyc(1); mode_we = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
  endtask

  task automatic pulse_reti();
    irq_reti = 1'b1; cyc(1); irq_reti = 1'b0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    ext_n = 2'b00; ser_rx = 1'b1;
    cyc(4);
    chk("R1 reset no request", {31'd0, irq_req}, 32'd0);
    ext_n = 2'b11; ser_rx = 1'b0;

    // R2/R3/R4/R5/R6/R8 table
    for (int i = 0; i < NROW; i++) begin
      wr_en(TBL[i][30:25]);
      wr_pri(TBL[i][24:20]);
      ext_n  = TBL[i][19:18];
      ser_rx = TBL[i][17];
      cyc(4);
      chk($sformatf("R2/R3/R4/R5 row %0d req", i), {31'd0, irq_req}, {31'd0, TBL[i][16]});
      if (TBL[i][16])
        chk($sformatf("R4/R5/R6 row %0d vector", i), {16'd0, irq_vector}, {16'd0, TBL[i][15:0]});
    end
    ext_n = 2'b11; ser_rx = 1'b0;

    // R8 level not latched
    wr_en(6'b111111); wr_pri(5'b00000);
    ext_n = 2'b10; cyc(4);
    chk("R8 level low requests", {15'd0, irq_req, irq_vector}, {15'd0, 1'b1, 16'h0003});
    ext_n = 2'b11; cyc(4);
    chk("R8 level release withdraws", {31'd0, irq_req}, 32'd0);

    // R9 edge mode on external 0
    wr_mode(2'b01); cyc(2);
    ext_n[0] = 1'b0;
    cyc(2);
    chk("R9 flag not yet set after two edges", {31'd0, irq_req}, 32'd0);
    cyc(1);
    chk("R9 flag set on third edge", {15'd0, irq_req, irq_vector}, {15'd0, 1'b1, 16'h0003});
    ext_n[0] = 1'b1; cyc(3);
    chk("R9 flag latched after pin release", {31'd0, irq_req}, 32'd1);
    pulse_ack();
    pulse_reti();
    cyc(1);
    chk("R9 ack clears edge flag", {31'd0, irq_req}, 32'd0);
    wr_mode(2'b00); cyc(2);

    // R10 timer 1
    tmr_ovf[1] = 1'b1; cyc(1); tmr_ovf[1] = 1'b0; cyc(1);
    chk("R10 timer flag latched", {15'd0, irq_req, irq_vector}, {15'd0, 1'b1, 16'h001B});
    pulse_ack();
    chk("R7 low handler blocks same level", {31'd0, irq_req}, 32'd0);
    pulse_reti();
    cyc(1);
    chk("R10 ack clears timer flag", {31'd0, irq_req}, 32'd0);

    // R11 serial
    ser_tx = 1'b1; cyc(1);
    chk("R11 transmit flag requests", {15'd0, irq_req, irq_vector}, {15'd0, 1'b1, 16'h0023});
    pulse_ack();
    pulse_reti();
    cyc(1);
    chk("R11 ack leaves serial pending", {15'd0, irq_req, irq_vector}, {15'd0, 1'b1, 16'h0023});
    ser_tx = 1'b0; ser_rx = 1'b1; cyc(1);
    chk("R11 receive flag requests", {15'd0, irq_req, irq_vector}, {15'd0, 1'b1, 16'h0023});

    // R7/R12 nesting
    pulse_ack();
    ext_n = 2'b01; cyc(4);
    chk("R7 equal low level blocked", {31'd0, irq_req}, 32'd0);
    wr_pri(5'b00001);
    ext_n = 2'b00; cyc(4);
    chk("R7 high preempts low handler", {15'd0, irq_req, irq_vector}, {15'd0, 1'b1, 16'h0003});
    pulse_ack();
    wr_pri(5'b00101); cyc(1);
    chk("R7 high blocked under high handler", {31'd0, irq_req}, 32'd0);
    pulse_reti();
    cyc(1);
    chk("R12 return clears high first", {15'd0, irq_req, irq_vector}, {15'd0, 1'b1, 16'h0003});
    ext_n = 2'b11; wr_pri(5'b00000); cyc(4);
    chk("R12 low still in service", {31'd0, irq_req}, 32'd0);
    pulse_reti();
    cyc(1);
    chk("R12 return clears low", {15'd0, irq_req, irq_vector}, {15'd0, 1'b1, 16'h0023});
    ser_rx = 1'b0; cyc(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule